// File: doc/BRIEF.md
# Configuration Security and Power-Up Controller

This block sits between a configuration access port and the configuration memory of a programmable device. It decides whether each read, program or erase request may proceed, based on two protection bits. The read lock hides the stored pattern and also blocks programming, but it leaves erase available. Only a granted erase clears it. The write lock blocks every change to the memory until an explicit release command removes it. Each accepted command receives a one-cycle grant or deny pulse on the bit that matches its opcode. Every refused command also pulses a common error flag.

The same block also sequences the device from supply ramp to operation. While the supply indication is low, the device is held quiescent. In that state the outputs and the access port are off and the pin pull-ups are on. When the supply becomes good, a programmed device passes through a timed initialisation phase. At the end of that phase it emits a one-cycle register-initialise pulse, then enters user operation. An erased device goes instead to a blank state, where the outputs stay off and the pull-ups stay on, but the access port is enabled so that the memory can be programmed.

Top module: `cfg_guard_seq`

## Requirements
- R1: Opcode 0 is read. It is granted when the read lock is clear and denied when the read lock is set.
- R2: Opcode 1 is program. It is denied when either the read lock or the write lock is set, and granted otherwise.
- R3: Opcode 2 is erase. It is granted whenever the write lock is clear, even with the read lock set. A granted erase clears the read lock.
- R4: The read lock is cleared by a granted erase and by nothing else. It survives supply drops and the write-lock release.
- R5: Opcode 3 sets the read lock, opcode 4 sets the write lock and opcode 5 releases the write lock. Opcodes 4 and 5 are always granted. While the write lock is set, opcodes 1, 2 and 3 are denied.
- R6: After reset, and while the supply indication is low, out_en=0, pullup_en=1 and jtag_en=0. Commands issued in this state and during initialisation produce no grant, no deny and no error.
- R7: When the supply is good and the blank flag is low, the quiescent state moves to initialisation. Initialisation lasts INIT_CYCLES cycles, and reg_init is high only in the last of them. The next cycle is user operation, with out_en=1, pullup_en=0 and jtag_en=1.
- R8: When the supply is good and the blank flag is high, the device enters the blank state. In that state out_en=0, pullup_en=1 and jtag_en=1, and commands are accepted.
- R9: A low supply indication in any state returns the controller to quiescent on the next cycle.
- R10: A command accepted in cycle n is answered in cycle n+1. The answer is a pulse on exactly one of cmd_grant[op] or cmd_deny[op]. cmd_err pulses with every deny. Reserved opcodes 6 and 7 raise only cmd_err.
- R11: A blank flag rising in user operation moves the controller to the blank state. A blank flag falling in the blank state starts initialisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Internal supply above the safe threshold |
| blank_flag | input | 1 | Configuration memory holds no pattern |
| cmd_valid | input | 1 | Command request strobe |
| cmd_op | input | 3 | Command opcode (see R1, R2, R3, R5, R10) |
| cmd_grant | output | 6 | One-cycle grant, one bit per opcode |
| cmd_deny | output | 6 | One-cycle deny, one bit per opcode |
| cmd_err | output | 1 | One-cycle error flag for a refused command |
| out_en | output | 1 | User output enable gate |
| pullup_en | output | 1 | Pin pull-up enable |
| jtag_en | output | 1 | Configuration access port enable |
| reg_init | output | 1 | One-cycle user register initialise pulse |

## Verification
On every cycle, the assertions check several local rules. These are the lock-based refusals of read, program and erase, the rule that the read lock falls only together with an erase grant, the single-response rule, silence while commands are not accepted, the drop to quiescent after a low supply, and the single-cycle initialise pulse followed by user operation. Some behaviour can only be shown by the bench's scenarios. These are the exact length of initialisation, the persistence of the read lock across supply drops and write-lock releases, the transitions between blank and user states, and the agreement of every grant and deny with a lock history built up over long random command streams.

// File: rtl/cgs_pkg.sv
package cgs_pkg;

   typedef enum logic [1:0] {
      PS_QUIET = 2'd0,
      PS_INIT  = 2'd1,
      PS_RUN   = 2'd2,
      PS_BLANK = 2'd3
   } pwr_state_e;

   localparam int OP_W    = 3;
   localparam int NUM_OPS = 6;

   localparam logic [OP_W-1:0] OP_READ    = 3'd0;
   localparam logic [OP_W-1:0] OP_PROG    = 3'd1;
   localparam logic [OP_W-1:0] OP_ERASE   = 3'd2;
   localparam logic [OP_W-1:0] OP_LOCK_RD = 3'd3;
   localparam logic [OP_W-1:0] OP_LOCK_WR = 3'd4;
   localparam logic [OP_W-1:0] OP_FREE_WR = 3'd5;

   // Permission rule: which opcodes may proceed under the current locks.
   function automatic logic op_allowed(input logic [OP_W-1:0] op,
                                       input logic rd_lock,
                                       input logic wr_lock);
      logic ok;
      case (op)
         OP_READ:    ok = !rd_lock;
         OP_PROG:    ok = !rd_lock && !wr_lock;
         OP_ERASE:   ok = !wr_lock;
         OP_LOCK_RD: ok = !wr_lock;
         OP_LOCK_WR: ok = 1'b1;
         OP_FREE_WR: ok = 1'b1;
         default:    ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/cgs_power_seq.sv
module cgs_power_seq
   import cgs_pkg::*;
#(
   parameter int INIT_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic blank_flag,
   output logic out_en,
   output logic pullup_en,
   output logic jtag_en,
   output logic reg_init
);

   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("cgs_power_seq: INIT_CYCLES must be at least 1");
   end

   pwr_state_e state_q, state_d;
   logic       init_last;

   // Variant choice: a single-cycle phase needs no counter.
   if (INIT_CYCLES == 1) begin : g_no_cnt
      assign init_last = 1'b1;
   end else begin : g_cnt
      localparam int CW = $clog2(INIT_CYCLES);
      localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (state_q == PS_INIT && supply_ok && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
         end else begin
            cnt_q <= '0;
         end
      end
      assign init_last = (cnt_q == LAST);
   end

   always_comb begin
      state_d = state_q;
      if (!supply_ok) begin
         state_d = PS_QUIET;
      end else begin
         case (state_q)
            PS_QUIET: state_d = blank_flag ? PS_BLANK : PS_INIT;
            PS_INIT:  state_d = init_last ? PS_RUN : PS_INIT;
            PS_RUN:   state_d = blank_flag ? PS_BLANK : PS_RUN;
            PS_BLANK: state_d = blank_flag ? PS_BLANK : PS_INIT;
            default:  state_d = PS_QUIET;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PS_QUIET;
      else        state_q <= state_d;
   end

   assign out_en    = (state_q == PS_RUN);
   assign pullup_en = (state_q != PS_RUN);
   assign jtag_en   = (state_q == PS_RUN) || (state_q == PS_BLANK);
   assign reg_init  = (state_q == PS_INIT) && init_last && supply_ok;

   AST_QUIET_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> (!out_en && pullup_en && !jtag_en)); // R9
   AST_INIT_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_init |=> !reg_init); // R7
   AST_RUN_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      reg_init |=> (out_en && jtag_en && !pullup_en)); // R7

endmodule

// File: rtl/cgs_sec_gate.sv
module cgs_sec_gate
   import cgs_pkg::*;
#(
   parameter bit RD_LOCK_INIT = 1'b0,
   parameter bit WR_LOCK_INIT = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               accept,
   input  logic               cmd_valid,
   input  logic [OP_W-1:0]    cmd_op,
   output logic [NUM_OPS-1:0] cmd_grant,
   output logic [NUM_OPS-1:0] cmd_deny,
   output logic               cmd_err
);

   if (NUM_OPS > (1 << OP_W)) begin : g_bad_ops
      $error("cgs_sec_gate: opcode field too narrow");
   end

   logic req_ok, allowed_now;
   logic rd_lock_q, wr_lock_q;
   logic err_q;

   assign req_ok      = cmd_valid && accept;
   assign allowed_now = op_allowed(cmd_op, rd_lock_q, wr_lock_q);

   for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
      logic hit, g_q, d_q;
      assign hit = req_ok && (cmd_op == OP_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            g_q <= 1'b0;
            d_q <= 1'b0;
         end else begin
            g_q <= hit && allowed_now;
            d_q <= hit && !allowed_now;
         end
      end
      assign cmd_grant[i] = g_q;
      assign cmd_deny[i]  = d_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_lock_q <= RD_LOCK_INIT;
         wr_lock_q <= WR_LOCK_INIT;
         err_q     <= 1'b0;
      end else begin
         err_q <= req_ok && !allowed_now;
         if (req_ok && allowed_now) begin
            case (cmd_op)
               OP_ERASE:   rd_lock_q <= 1'b0;
               OP_LOCK_RD: rd_lock_q <= 1'b1;
               OP_LOCK_WR: wr_lock_q <= 1'b1;
               OP_FREE_WR: wr_lock_q <= 1'b0;
               default:    ;
            endcase
         end
      end
   end

   assign cmd_err = err_q;

   AST_READ_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ok && cmd_op == OP_READ && rd_lock_q) |=> cmd_deny[OP_READ]); // R1
   AST_PROG_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ok && cmd_op == OP_PROG && (rd_lock_q || wr_lock_q)) |=> !cmd_grant[OP_PROG]); // R2
   AST_RDLOCK_ONLY_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_lock_q) |-> cmd_grant[OP_ERASE]); // R4
   AST_ERASE_WR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ok && cmd_op == OP_ERASE && wr_lock_q) |=> cmd_deny[OP_ERASE]); // R5
   AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_grant | cmd_deny)); // R10
   AST_SILENT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ok |=> (cmd_grant == '0 && cmd_deny == '0 && !cmd_err)); // R6

endmodule

// File: rtl/cfg_guard_seq.sv
module cfg_guard_seq
   import cgs_pkg::*;
#(
   parameter int INIT_CYCLES  = 16,
   parameter bit RD_LOCK_INIT = 1'b0,
   parameter bit WR_LOCK_INIT = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               supply_ok,
   input  logic               blank_flag,
   input  logic               cmd_valid,
   input  logic [OP_W-1:0]    cmd_op,
   output logic [NUM_OPS-1:0] cmd_grant,
   output logic [NUM_OPS-1:0] cmd_deny,
   output logic               cmd_err,
   output logic               out_en,
   output logic               pullup_en,
   output logic               jtag_en,
   output logic               reg_init
);

   logic port_on;

   cgs_power_seq #(.INIT_CYCLES(INIT_CYCLES)) u_pwr (
      .clk        (clk),
      .rst_n      (rst_n),
      .supply_ok  (supply_ok),
      .blank_flag (blank_flag),
      .out_en     (out_en),
      .pullup_en  (pullup_en),
      .jtag_en    (port_on),
      .reg_init   (reg_init)
   );

   cgs_sec_gate #(.RD_LOCK_INIT(RD_LOCK_INIT), .WR_LOCK_INIT(WR_LOCK_INIT)) u_sec (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (port_on),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_grant (cmd_grant),
      .cmd_deny  (cmd_deny),
      .cmd_err   (cmd_err)
   );

   assign jtag_en = port_on;

   AST_ERR_WITH_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_deny != '0) |-> cmd_err); // R10
   AST_BLANK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (jtag_en && !out_en) |-> pullup_en); // R8

endmodule

// File: tb/tb_cfg_guard_seq.sv
module tb_cfg_guard_seq;
   localparam int CLK_PERIOD = 10;
   localparam int INIT_N = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       supply_ok = 1'b0, blank_flag = 1'b0, cmd_valid = 1'b0;
   logic [2:0] cmd_op = 3'd0;
   logic [5:0] cmd_grant, cmd_deny;
   logic       cmd_err, out_en, pullup_en, jtag_en, reg_init;

   int checks = 0;
   int errors = 0;

   // Reference model state: 0 quiet, 1 init, 2 run, 3 blank
   int       m_st = 0;
   int       m_cnt = 0;
   bit       m_rd = 0, m_wr = 0;
   bit [5:0] m_g = '0, m_d = '0;
   bit       m_e = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_guard_seq #(.INIT_CYCLES(INIT_N)) dut (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .blank_flag(blank_flag),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_grant(cmd_grant),
      .cmd_deny(cmd_deny), .cmd_err(cmd_err), .out_en(out_en),
      .pullup_en(pullup_en), .jtag_en(jtag_en), .reg_init(reg_init)
   );

   function automatic bit allowed(input int op, input bit rd, input bit wr);
      case (op)
         0: return !rd;
         1: return !rd && !wr;
         2: return !wr;
         3: return !wr;
         4: return 1'b1;
         5: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                      input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input bit sup, input bit blk, input bit v, input int op);
      supply_ok  = sup;
      blank_flag = blk;
      cmd_valid  = v;
      cmd_op     = 3'(op);
      @(posedge clk);
      begin : model
         bit req;
         bit ok;
         bit last;
         int nxt;
         req  = v && (m_st == 2 || m_st == 3);
         ok   = allowed(op, m_rd, m_wr);
         for (int i = 0; i < 6; i++) begin
            m_g[i] = req && (op == i) && ok;
            m_d[i] = req && (op == i) && !ok;
         end
         m_e = req && !ok;
         if (req && ok) begin
            if (op == 2) m_rd = 0;
            if (op == 3) m_rd = 1;
            if (op == 4) m_wr = 1;
            if (op == 5) m_wr = 0;
         end
         last = (m_st == 1) && (m_cnt == INIT_N - 1);
         if (!sup) nxt = 0;
         else case (m_st)
            0: nxt = blk ? 3 : 1;
            1: nxt = last ? 2 : 1;
            2: nxt = blk ? 3 : 2;
            default: nxt = blk ? 3 : 1;
         endcase
         if (m_st == 1 && sup && !last) m_cnt = m_cnt + 1;
         else m_cnt = 0;
         m_st = nxt;
      end
      @(negedge clk);
      begin : cmp
         logic [15:0] ac, ec, ap, ep;
         ac = {3'b0, cmd_grant, cmd_deny, cmd_err};
         ec = {3'b0, m_g, m_d, m_e};
         ap = {12'b0, out_en, pullup_en, jtag_en, reg_init};
         ep = {12'b0, m_st == 2, m_st != 2, m_st >= 2,
               (m_st == 1) && (m_cnt == INIT_N - 1) && supply_ok};
         chk(ac == ec, "R10 command response", ac, ec);
         chk(ap == ep, "R7 power outputs", ap, ep);
      end
   endtask

   task automatic power_up();
      step(1, 0, 0, 0);
      for (int i = 0; i < INIT_N; i++) step(1, 0, 0, 0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int pulses;
      bit sup, blk;
      repeat (3) @(negedge clk);
      chk(!out_en && pullup_en && !jtag_en && !reg_init, "R6 reset state",
          {out_en, pullup_en, jtag_en, reg_init}, 4'b0100);
      rst_n = 1'b1;

      // R6: commands while quiet are ignored
      step(0, 0, 1, 0);
      chk(cmd_grant == 0 && cmd_deny == 0 && !cmd_err, "R6 quiet ignores", cmd_grant, 0);

      // R7: init length and pulse
      pulses = 0;
      step(1, 0, 0, 0);
      for (int i = 0; i < INIT_N; i++) begin
         if (reg_init) pulses++;
         chk(!out_en, "R7 no outputs during init", out_en, 0);
         step(1, 0, 1, 0);
      end
      chk(pulses == 1, "R7 single init pulse", pulses, 1);
      chk(out_en && !pullup_en && jtag_en, "R7 user operation",
          {out_en, pullup_en, jtag_en}, 3'b101);

      // R1 / R2 / R3
      step(1, 0, 1, 0);
      chk(cmd_grant[0], "R1 read granted unlocked", cmd_grant, 6'b1);
      step(1, 0, 1, 3);
      step(1, 0, 1, 0);
      chk(cmd_deny[0] && cmd_err, "R1 read denied when locked", cmd_deny, 6'b1);
      step(1, 0, 1, 1);
      chk(cmd_deny[1], "R2 program denied by read lock", cmd_deny, 6'b10);
      step(1, 0, 1, 2);
      chk(cmd_grant[2], "R3 erase granted with read lock", cmd_grant, 6'b100);
      step(1, 0, 1, 0);
      chk(cmd_grant[0], "R3 erase cleared read lock", cmd_grant, 6'b1);

      // R4: read lock persists across drop and write release
      step(1, 0, 1, 3);
      step(0, 0, 0, 0);
      chk(!out_en && pullup_en && !jtag_en, "R9 drop to quiet",
          {out_en, pullup_en, jtag_en}, 3'b010);
      power_up();
      step(1, 0, 1, 5);
      step(1, 0, 1, 0);
      chk(cmd_deny[0], "R4 read lock persists", cmd_deny, 6'b1);
      step(1, 0, 1, 2);

      // R5: write lock
      step(1, 0, 1, 4);
      chk(cmd_grant[4], "R5 write lock granted", cmd_grant, 6'b10000);
      step(1, 0, 1, 1);
      chk(cmd_deny[1], "R5 program denied", cmd_deny, 6'b10);
      step(1, 0, 1, 2);
      chk(cmd_deny[2], "R5 erase denied", cmd_deny, 6'b100);
      step(1, 0, 1, 3);
      chk(cmd_deny[3], "R5 read lock set denied", cmd_deny, 6'b1000);
      step(1, 0, 1, 5);
      step(1, 0, 1, 1);
      chk(cmd_grant[1], "R5 program after release", cmd_grant, 6'b10);

      // R10: reserved opcode
      step(1, 0, 1, 7);
      chk(cmd_err && cmd_grant == 0 && cmd_deny == 0, "R10 reserved opcode",
          {cmd_err, cmd_grant, cmd_deny}, 13'h1000);

      // R11 / R8: blank transitions
      step(1, 1, 0, 0);
      chk(!out_en && pullup_en && jtag_en, "R11 run to blank",
          {out_en, pullup_en, jtag_en}, 3'b011);
      step(1, 1, 1, 0);
      chk(cmd_grant[0], "R8 commands in blank", cmd_grant, 6'b1);
      step(1, 0, 0, 0);
      chk(!jtag_en && !out_en, "R11 blank to init", {out_en, jtag_en}, 0);
      step(1, 0, 1, 0);
      chk(cmd_grant == 0, "R6 init ignores commands", cmd_grant, 0);
      step(0, 1, 0, 0);
      step(1, 1, 0, 0);
      chk(jtag_en && !out_en, "R8 quiet to blank", {out_en, jtag_en}, 2'b01);

      // Random phase
      void'($urandom(32'd7321));
      sup = 1;
      blk = 0;
      for (int n = 0; n < 3000; n++) begin
         if (($urandom % 100) < 3) sup = !sup;
         if (!sup && ($urandom % 4) == 0) sup = 1;
         if (($urandom % 100) < 2) blk = !blk;
         step(sup, blk, ($urandom % 10) < 6, int'($urandom % 8));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule